// File: doc/BRIEF.md
# PHY management register responder

This block stands in for the management control register that a MAC offers for reaching its PHY. The host writes one 32-bit word that holds a PHY address, a PHY register number, an opcode and an interrupt-on-completion request. The block answers without any serial management traffic. It looks up a fixed 16-bit value for the selected PHY register, places it in the data field and sets the ready bit. All of the fixed values describe a gigabit PHY whose link is up.

The block also checks each access. If the access asks for the completion interrupt, or targets any PHY address other than the single one it models, the block sets the error bit and returns zero data. If the access is valid but names a PHY register that has no fixed value, the block returns zero data and raises a separate warning flag. The host polls the register output until ready is 1, then reads the data and the status bits.

Top module: `mgmt_phy_responder`

## Requirements
- R1: After reset, `ctl_q` is 0x0000_0000 and `unknown_reg` is 0.
- R2: The cycle after a write, `ctl_q` holds the written bits [27:16] (register number [20:16], PHY address [25:21], opcode [27:26]) and bit [29] (interrupt request). Data [15:0], ready [28], error [30] and reserved bit [31] all read 0, whatever the host wrote into them. `unknown_reg` reads 0.
- R3: If no new write arrives, ready [28] becomes 1 in the second cycle after the write.
- R4: For a valid access, the data field returns a fixed value that depends on the PHY register number. Register 1 returns 0x796D. Register 2 returns 0x02A8. Register 3 returns 0x0380. Register 10 returns 0x7C00. Register 15 returns 0x3000. Register 20 returns 0x0180.
- R5: For a valid access to any other register number, the data field is 0x0000 and `unknown_reg` is 1 together with ready. The next write clears `unknown_reg`.
- R6: If the interrupt request bit [29] is 1, error [30] is set together with ready, the data field is 0 and `unknown_reg` stays 0.
- R7: If the PHY address [25:21] is not 1, error [30] is set together with ready, the data field is 0 and `unknown_reg` stays 0.
- R8: The opcode (1 = write, 2 = read) does not change the returned value. A write to a PHY register returns the same fixed value as a read.
- R9: A write in the cycle right after another write restarts the access. Ready stays 0, and the completed result belongs to the later write.
- R10: Once ready is 1, `ctl_q` and `unknown_reg` hold their values until the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host writes the control register in this cycle |
| wr_data | input | 32 | Value the host writes |
| ctl_q | output | 32 | Registered read value of the control register |
| unknown_reg | output | 1 | The completed access named a PHY register that has no fixed value |

## Verification
The assertions check the following on every cycle:
- The reserved bit stays 0.
- A write drops ready.
- Ready rises one cycle after a write that no other write follows.
- An error or an unknown-register warning always comes with zero data.
- A completed access with the interrupt request set, or with a foreign PHY address, always carries the error bit.
- A finished result stays stable until the next write.

Only the bench scenarios can show the rest:
- Each PHY register number returns the right fixed value.
- The opcode is ignored.
- Host-written data, ready and error bits are discarded.
- Back-to-back writes complete with the later command.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
  localparam int CSR_W   = 32;
  localparam int DATA_W  = 16;
  localparam int RNUM_W  = 5;
  localparam int PADR_W  = 5;
  localparam int OPC_W   = 2;

  localparam int DATA_LSB = 0;
  localparam int RNUM_LSB = 16;
  localparam int PADR_LSB = RNUM_LSB + RNUM_W;
  localparam int OPC_LSB  = PADR_LSB + PADR_W;
  localparam int RDY_BIT  = OPC_LSB + OPC_W;
  localparam int IRQ_BIT  = RDY_BIT + 1;
  localparam int ERR_BIT  = IRQ_BIT + 1;

  // Bits kept from a host write: register number, PHY address, opcode, irq request
  localparam logic [CSR_W-1:0] KEEP_MASK =
    (((CSR_W'(1) << (RNUM_W + PADR_W + OPC_W)) - CSR_W'(1)) << RNUM_LSB)
    | (CSR_W'(1) << IRQ_BIT);

  typedef enum logic [RNUM_W-1:0] {
    PR_STAT   = 5'd1,
    PR_ID_HI  = 5'd2,
    PR_ID_LO  = 5'd3,
    PR_GSTAT  = 5'd10,
    PR_XSTAT  = 5'd15,
    PR_CABLE  = 5'd20
  } phy_reg_e;
endpackage

// File: rtl/mgmt_phy_table.sv
module mgmt_phy_table
  import mgmt_phy_pkg::*;
(
  input  logic [RNUM_W-1:0] rnum,
  output logic [DATA_W-1:0] value,
  output logic              hit
);
  always_comb begin
    hit   = 1'b1;
    value = '0;
    unique case (rnum)
      PR_STAT:  value = DATA_W'(16'h796D);
      PR_ID_HI: value = DATA_W'(16'h02A8);
      PR_ID_LO: value = DATA_W'(16'h0380);
      PR_GSTAT: value = DATA_W'(16'h7C00);
      PR_XSTAT: value = DATA_W'(16'h3000);
      PR_CABLE: value = DATA_W'(16'h0180);
      default: begin
        hit   = 1'b0;
        value = '0;
      end
    endcase
  end
endmodule

// File: rtl/mgmt_cmd_check.sv
module mgmt_cmd_check
  import mgmt_phy_pkg::*;
#(
  parameter int PHY_SELF = 1
) (
  input  logic [PADR_W-1:0] padr,
  input  logic              irq_req,
  output logic              bad_mode,
  output logic              bad_addr,
  output logic              err
);
  localparam logic [PADR_W-1:0] SELF = PADR_W'(PHY_SELF);
  always_comb begin
    bad_mode = irq_req;
    bad_addr = (padr != SELF);
    err      = bad_mode | bad_addr;
  end
endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
  import mgmt_phy_pkg::*;
#(
  parameter int PHY_SELF = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] ctl_q,
  output logic             unknown_reg
);
  logic              pend_q;
  logic [DATA_W-1:0] tbl_val;
  logic              tbl_hit;
  logic              chk_mode, chk_addr, chk_err;

  mgmt_phy_table u_table (
    .rnum  (ctl_q[RNUM_LSB +: RNUM_W]),
    .value (tbl_val),
    .hit   (tbl_hit)
  );

  mgmt_cmd_check #(.PHY_SELF(PHY_SELF)) u_check (
    .padr     (ctl_q[PADR_LSB +: PADR_W]),
    .irq_req  (ctl_q[IRQ_BIT]),
    .bad_mode (chk_mode),
    .bad_addr (chk_addr),
    .err      (chk_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q       <= '0;
      pend_q      <= 1'b0;
      unknown_reg <= 1'b0;
    end else if (wr_en) begin
      ctl_q       <= wr_data & KEEP_MASK;
      pend_q      <= 1'b1;
      unknown_reg <= 1'b0;
    end else if (pend_q) begin
      ctl_q[DATA_LSB +: DATA_W] <= chk_err ? '0 : tbl_val;
      ctl_q[RDY_BIT]            <= 1'b1;
      ctl_q[ERR_BIT]            <= chk_err;
      unknown_reg               <= !chk_err && !tbl_hit;
      pend_q                    <= 1'b0;
    end
  end

  localparam logic [PADR_W-1:0] SELF_A = PADR_W'(PHY_SELF);

  AST_RSV_LOW: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CSR_W-1] == 1'b0); // R2
  AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!ctl_q[RDY_BIT] && !unknown_reg)); // R2
  AST_READY_NEXT: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !wr_en) |=> ctl_q[RDY_BIT]); // R3
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    ctl_q[ERR_BIT] |-> (ctl_q[DATA_LSB +: DATA_W] == '0 && !unknown_reg)); // R6
  AST_IRQ_ERR: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[RDY_BIT] && ctl_q[IRQ_BIT]) |-> ctl_q[ERR_BIT]); // R6
  AST_PHY_ERR: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[RDY_BIT] && ctl_q[PADR_LSB +: PADR_W] != SELF_A) |-> ctl_q[ERR_BIT]); // R7
  AST_UNK_ZERO: assert property (@(posedge clk) disable iff (rst)
    unknown_reg |-> (ctl_q[DATA_LSB +: DATA_W] == '0 && ctl_q[RDY_BIT])); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && ctl_q[RDY_BIT]) |=> ($stable(ctl_q) && $stable(unknown_reg))); // R10
endmodule

// File: tb/mgmt_phy_responder_bench.sv
module mgmt_phy_responder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctl_q;
  logic        unknown_reg;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          at;
    logic [31:0] val;
    logic        unk;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mgmt_phy_responder u_mgmt_phy_responder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_q(ctl_q), .unknown_reg(unknown_reg)
  );

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rn, input logic irq,
                                     input logic [15:0] junk);
    return {1'b1, 1'b1, irq, 1'b1, op, phy, rn, junk};
  endfunction

  function automatic logic [31:0] stage_of(input logic [31:0] d);
    return {2'b00, d[29], 1'b0, d[27:16], 16'h0000};
  endfunction

  task automatic final_of(input logic [31:0] d, output logic [31:0] v, output logic u);
    logic        err;
    logic [15:0] t;
    logic        hit;
    hit = 1'b1;
    case (d[20:16])
      5'd1:  t = 16'h796D;
      5'd2:  t = 16'h02A8;
      5'd3:  t = 16'h0380;
      5'd10: t = 16'h7C00;
      5'd15: t = 16'h3000;
      5'd20: t = 16'h0180;
      default: begin t = 16'h0000; hit = 1'b0; end
    endcase
    err = d[29] || (d[25:21] != 5'd1);
    v = stage_of(d) | 32'h1000_0000 | (err ? 32'h4000_0000 : {16'h0, t});
    u = !err && !hit;
  endtask

  task automatic push(input int at, input logic [31:0] v, input logic u, input string tag);
    exp_t e;
    e.at = at; e.val = v; e.unk = u; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_write(input logic [31:0] d, input string tag);
    logic [31:0] v;
    logic        u;
    final_of(d, v, u);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    push(cyc + 1, stage_of(d), 1'b0, "R2");
    push(cyc + 2, v, u, tag);
    push(cyc + 4, v, u, "R10");
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (e.at != cyc || ctl_q !== e.val || unknown_reg !== e.unk) begin
        bad++;
        $display("FAIL %s: at %0d got ctl=%h unk=%b, expected ctl=%h unk=%b (due %0d)",
                 e.tag, cyc, ctl_q, unknown_reg, e.val, e.unk, e.at);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, vb;
    logic        ua, ub;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (ctl_q !== 32'h0 || unknown_reg !== 1'b0) begin
      bad++;
      $display("FAIL R1: got ctl=%h unk=%b, expected ctl=00000000 unk=0", ctl_q, unknown_reg);
    end
    // R4: fixed table, read opcode, junk in discarded bits
    do_write(mk(2'd2, 5'd1, 5'd1,  1'b0, 16'hFFFF), "R4");
    do_write(mk(2'd2, 5'd1, 5'd2,  1'b0, 16'h1234), "R4");
    do_write(mk(2'd2, 5'd1, 5'd3,  1'b0, 16'h0000), "R4");
    do_write(mk(2'd2, 5'd1, 5'd10, 1'b0, 16'hA5A5), "R4");
    do_write(mk(2'd2, 5'd1, 5'd15, 1'b0, 16'h5A5A), "R4");
    do_write(mk(2'd2, 5'd1, 5'd20, 1'b0, 16'h8001), "R4");
    // R8: write opcode gives same value
    do_write(mk(2'd1, 5'd1, 5'd1,  1'b0, 16'h0F0F), "R8");
    do_write(mk(2'd1, 5'd1, 5'd15, 1'b0, 16'h0F0F), "R8");
    // R5: unknown register numbers, then cleared by a known access
    do_write(mk(2'd2, 5'd1, 5'd7,  1'b0, 16'hBEEF), "R5");
    do_write(mk(2'd2, 5'd1, 5'd31, 1'b0, 16'h0000), "R5");
    do_write(mk(2'd2, 5'd1, 5'd2,  1'b0, 16'h0000), "R5");
    // R6: interrupt request
    do_write(mk(2'd2, 5'd1, 5'd1,  1'b1, 16'h1111), "R6");
    do_write(mk(2'd2, 5'd1, 5'd9,  1'b1, 16'h1111), "R6");
    // R7: foreign PHY address
    do_write(mk(2'd2, 5'd3, 5'd1,  1'b0, 16'h2222), "R7");
    do_write(mk(2'd2, 5'd0, 5'd8,  1'b0, 16'h2222), "R7");
    do_write(mk(2'd1, 5'd31, 5'd20, 1'b0, 16'h2222), "R7");
    // R9: back-to-back writes, later one wins
    va = mk(2'd2, 5'd1, 5'd1, 1'b0, 16'h0);
    vb = mk(2'd2, 5'd1, 5'd7, 1'b0, 16'h0);
    final_of(va, vb, ua);
    vb = mk(2'd2, 5'd1, 5'd7, 1'b0, 16'h0);
    final_of(vb, va, ub);
    @(negedge clk);
    wr_en = 1'b1; wr_data = mk(2'd2, 5'd1, 5'd1, 1'b0, 16'h0);
    push(cyc + 1, stage_of(wr_data), 1'b0, "R9");
    @(negedge clk);
    wr_data = vb;
    push(cyc + 1, stage_of(vb), 1'b0, "R9");
    push(cyc + 2, va, ub, "R9");
    push(cyc + 5, va, ub, "R10");
    @(negedge clk);
    wr_en = 1'b0;
    repeat (8) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      if (sb.size() != 0) begin
        bad++;
        $display("FAIL scoreboard: got %0d pending, expected 0", sb.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule